// File: doc/BRIEF.md
# Programmable Priority Interrupt Resolver

This block picks, out of a programmable rank table, the most urgent interrupt source that is currently active, and it does so separately for the two interrupt classes: the fast class and the normal class. Each entry of the rank table (a slot) holds an enable flag and a 6-bit source number. The slot's position in the table gives its rank, and slot 0 is the most urgent. A source takes part only when its bit in the active vector is set. The active vector is the pending and enabled sources, already combined by the surrounding logic. The source's steering bit then sends it into the fast-class contest (bit = 1) or the normal-class contest (bit = 0).

Sources are split into two banks. Source numbers 0 to 31 look up bit N of the low bank. Source numbers 32 to 39 look up bit N-32 of the high bank. All slots are searched in one combinational pass. The two winners are packed into a 32-bit word, which is registered once. The surrounding logic holds the table storage, decodes register accesses and drives the interrupt lines.

Top module: `prio_resolver`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, `result` reads 0x003F003F. Reset is asynchronous and active-low, and its release is synchronized over two clock edges.
- R2: A slot takes part only when its enable flag is 1 and its source number is below 40. An enabled slot that holds a number from 40 to 63 never produces a winner.
- R3: A slot's source is a candidate only when its bit in the active vector is 1. With no active bit set, `result` is 0x003F003F.
- R4: Steering bit 1 places a candidate in the fast-class field. Steering bit 0 places it in the normal-class field.
- R5: Within each class, the candidate in the lowest-numbered slot wins.
- R6: The fast-class field is `result[15:0]`. Bit 15 is the found flag, bits 5:0 hold the winning source number, and bits 14:6 are 0.
- R7: The normal-class field is `result[31:16]`. Bit 31 is the found flag, bits 21:16 hold the winning source number, and bits 30:22 are 0.
- R8: A class with no candidate reads found = 0 with source number 0x3F in its field.
- R9: Source numbers 32 to 39 use bit N-32 of the high-bank active and steering vectors. Source numbers 0 to 31 use bit N of the low-bank vectors.
- R10: `result` reflects the inputs present before the previous rising clock edge. It changes exactly one cycle after an input change.
- R11: The fast-class and normal-class winners are chosen independently in the same cycle. Either class, both classes or neither class may report a winner.
- R12: When several slots name the same active source, that source is reported through the lowest-numbered slot that names it, and slots of lower rank cannot displace it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_lo | input | 32 | Active vector, sources 0..31 |
| act_hi | input | 8 | Active vector, sources 32..39 |
| steer_lo | input | 32 | Steering vector, sources 0..31 (1 = fast class) |
| steer_hi | input | 8 | Steering vector, sources 32..39 |
| slot_vld | input | 40 | Enable flag of each slot |
| slot_id | input | 240 | Source number of each slot, 6 bits per slot, slot i at bits 6i+5:6i |
| result | output | 32 | Packed winners: normal class in 31:16, fast class in 15:0 |

## Verification
The fast-class and normal-class contests run in the same cycle over the same slot table. The main risk is that a candidate of one class blocks or displaces the winner of the other. To provoke this, the bench fills every slot with a permutation of all 40 sources and drives pseudo-random active and steering vectors, so that both classes usually hold candidates at interleaved ranks. It then compares both fields against a rank-order model computed in the bench. A second case arises when a change in the inputs and the registered output meet in the same cycle. The bench samples just after the input change, where the old value is expected, and again one edge later, where the new value is expected.

// File: rtl/prio_pkg.sv
package prio_pkg;
  localparam int ID_W   = 6;
  localparam int FLD_W  = 16;
  localparam int RES_W  = 2 * FLD_W;
  localparam logic [ID_W-1:0]  NONE_ID  = '1;
  localparam logic [RES_W-1:0] IDLE_RES = {1'b0, 9'd0, NONE_ID, 1'b0, 9'd0, NONE_ID};

  typedef struct packed {
    logic            found;
    logic [ID_W-1:0] id;
  } pick_t;
endpackage

// File: rtl/rst_sync.sv
module rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/slot_decode.sv
module slot_decode #(
  parameter int NUM_SRC = 40,
  parameter int ID_W    = 6
) (
  input  logic               vld,
  input  logic [ID_W-1:0]    id,
  input  logic [NUM_SRC-1:0] act_all,
  input  logic [NUM_SRC-1:0] steer_all,
  output logic               fast_hit,
  output logic               norm_hit
);
  logic in_rng;
  logic act_bit;
  logic steer_bit;

  always_comb begin
    in_rng    = (int'(id) < NUM_SRC);
    act_bit   = 1'b0;
    steer_bit = 1'b0;
    if (in_rng) begin
      act_bit   = act_all[id];
      steer_bit = steer_all[id];
    end
    fast_hit = vld && in_rng && act_bit && steer_bit;
    norm_hit = vld && in_rng && act_bit && !steer_bit;
  end
endmodule

// File: rtl/winner_pick.sv
module winner_pick #(
  parameter int N    = 40,
  parameter int ID_W = 6
) (
  input  logic [N-1:0]      hit,
  input  logic [N*ID_W-1:0] ids,
  output logic              found,
  output logic [ID_W-1:0]   win_id
);
  always_comb begin
    found  = 1'b0;
    win_id = '1;
    // scan from the lowest rank upward so the most urgent slot is written last
    for (int i = N - 1; i >= 0; i--) begin
      if (hit[i]) begin
        found  = 1'b1;
        win_id = ids[i*ID_W +: ID_W];
      end
    end
  end
endmodule

// File: rtl/prio_resolver.sv
module prio_resolver #(
  parameter int NUM_SLOTS = 40,
  parameter int NUM_SRC   = 40,
  parameter int BANK_W    = 32,
  localparam int HI_W     = NUM_SRC - BANK_W,
  localparam int ID_W     = prio_pkg::ID_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [BANK_W-1:0]         act_lo,
  input  logic [HI_W-1:0]           act_hi,
  input  logic [BANK_W-1:0]         steer_lo,
  input  logic [HI_W-1:0]           steer_hi,
  input  logic [NUM_SLOTS-1:0]      slot_vld,
  input  logic [NUM_SLOTS*ID_W-1:0] slot_id,
  output logic [prio_pkg::RES_W-1:0] result
);
  import prio_pkg::*;

  logic                 rst_int_n;
  logic [NUM_SRC-1:0]   act_all;
  logic [NUM_SRC-1:0]   steer_all;
  logic [NUM_SLOTS-1:0] fast_hit;
  logic [NUM_SLOTS-1:0] norm_hit;
  pick_t                fast_pick;
  pick_t                norm_pick;
  logic [RES_W-1:0]     res_d;
  logic [RES_W-1:0]     res_q;

  rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  // high bank sits above the low bank, so source N >= BANK_W lands on bit N-BANK_W
  assign act_all   = {act_hi, act_lo};
  assign steer_all = {steer_hi, steer_lo};

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    slot_decode #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_dec (
      .vld       (slot_vld[s]),
      .id        (slot_id[s*ID_W +: ID_W]),
      .act_all   (act_all),
      .steer_all (steer_all),
      .fast_hit  (fast_hit[s]),
      .norm_hit  (norm_hit[s])
    );
  end

  winner_pick #(.N(NUM_SLOTS), .ID_W(ID_W)) u_fast (
    .hit    (fast_hit),
    .ids    (slot_id),
    .found  (fast_pick.found),
    .win_id (fast_pick.id)
  );

  winner_pick #(.N(NUM_SLOTS), .ID_W(ID_W)) u_norm (
    .hit    (norm_hit),
    .ids    (slot_id),
    .found  (norm_pick.found),
    .win_id (norm_pick.id)
  );

  always_comb begin
    res_d = '0;
    res_d[FLD_W + FLD_W - 1]   = norm_pick.found;
    res_d[FLD_W +: ID_W]       = norm_pick.id;
    res_d[FLD_W - 1]           = fast_pick.found;
    res_d[0 +: ID_W]           = fast_pick.id;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) res_q <= IDLE_RES;
    else            res_q <= res_d;
  end

  assign result = res_q;
endmodule

// File: rtl/prio_resolver_chk.sv
module prio_resolver_chk #(
  parameter int NUM_SLOTS = 40,
  parameter int NUM_SRC   = 40,
  parameter int BANK_W    = 32,
  localparam int HI_W     = NUM_SRC - BANK_W,
  localparam int ID_W     = prio_pkg::ID_W,
  localparam int IN_W     = 2 * NUM_SRC + NUM_SLOTS * (ID_W + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [BANK_W-1:0]         act_lo,
  input  logic [HI_W-1:0]           act_hi,
  input  logic [BANK_W-1:0]         steer_lo,
  input  logic [HI_W-1:0]           steer_hi,
  input  logic [NUM_SLOTS-1:0]      slot_vld,
  input  logic [NUM_SLOTS*ID_W-1:0] slot_id,
  input  logic [31:0]               result
);
  logic [IN_W-1:0] in_now;
  logic [IN_W-1:0] in_q;
  logic [2:0]      arm_cnt;
  logic            armed;
  logic            same_in;

  assign in_now  = {act_hi, act_lo, steer_hi, steer_lo, slot_vld, slot_id};
  assign armed   = (arm_cnt == 3'd5);
  assign same_in = (in_now == in_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_cnt <= 3'd0;
      in_q    <= '0;
    end else begin
      if (!armed) arm_cnt <= arm_cnt + 3'd1;
      in_q <= in_now;
    end
  end

  // R3
  no_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(act_lo == '0 && act_hi == '0) |-> result == 32'h003F003F);

  // R4
  fast_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past((&steer_lo) && (&steer_hi)) |-> !result[31]);

  // R4
  norm_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(steer_lo == '0 && steer_hi == '0) |-> !result[15]);

  // R8
  fast_idle_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !result[15] |-> result[5:0] == 6'h3F);

  // R8
  norm_idle_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !result[31] |-> result[21:16] == 6'h3F);

  // R2
  id_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (result[15] |-> int'(result[5:0]) < NUM_SRC) and
    (result[31] |-> int'(result[21:16]) < NUM_SRC));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(armed) && $past(same_in) |-> $stable(result));
endmodule

bind prio_resolver prio_resolver_chk #(
  .NUM_SLOTS (NUM_SLOTS),
  .NUM_SRC   (NUM_SRC),
  .BANK_W    (BANK_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .act_lo   (act_lo),
  .act_hi   (act_hi),
  .steer_lo (steer_lo),
  .steer_hi (steer_hi),
  .slot_vld (slot_vld),
  .slot_id  (slot_id),
  .result   (result)
);

// File: tb/test_prio_resolver.sv
module test_prio_resolver;
  localparam int NS = 40;
  localparam int NSRC = 40;

  logic        clk;
  logic        rst_n;
  logic [31:0] act_lo, steer_lo;
  logic [7:0]  act_hi, steer_hi;
  logic [NS-1:0]   slot_vld;
  logic [NS*6-1:0] slot_id;
  logic [5:0]  b_id [NS];
  logic [31:0] result;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] seed = 32'h1234_5679;

  prio_resolver i_prio_resolver (
    .clk(clk), .rst_n(rst_n),
    .act_lo(act_lo), .act_hi(act_hi),
    .steer_lo(steer_lo), .steer_hi(steer_hi),
    .slot_vld(slot_vld), .slot_id(slot_id),
    .result(result)
  );

  always_comb
    for (int i = 0; i < NS; i++) slot_id[i*6 +: 6] = b_id[i];

  initial clk = 1'b0;
  always #10 clk = ~clk;

  initial begin
    #(200000 * 20);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run hung, got timeout exp completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  // rank-order model: first matching slot from 0 upward wins per class
  function automatic logic [31:0] model();
    logic fv = 0, nv = 0;
    logic [5:0] fid = 6'h3F, nid = 6'h3F;
    for (int i = 0; i < NS; i++) begin
      int s = int'(b_id[i]);
      if (slot_vld[i] && s < NSRC) begin
        logic a  = (s < 32) ? act_lo[s]   : act_hi[s-32];
        logic st = (s < 32) ? steer_lo[s] : steer_hi[s-32];
        if (a && st && !fv)  begin fv = 1; fid = b_id[i]; end
        if (a && !st && !nv) begin nv = 1; nid = b_id[i]; end
      end
    end
    return {nv, 9'd0, nid, fv, 9'd0, fid};
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %08h exp %08h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_all();
    act_lo = '0; act_hi = '0; steer_lo = '0; steer_hi = '0; slot_vld = '0;
    for (int i = 0; i < NS; i++) b_id[i] = 6'(i);
  endtask

  task automatic set_src(int s, logic a, logic st);
    if (s < 32) begin act_lo[s] = a; steer_lo[s] = st; end
    else        begin act_hi[s-32] = a; steer_hi[s-32] = st; end
  endtask

  initial begin
    logic [31:0] prev;
    rst_n = 1'b0;
    clear_all();
    act_lo = '1; act_hi = '1; slot_vld = '1;
    repeat (3) @(negedge clk);
    // R1: held idle while reset asserted, despite active inputs
    chk("R1 in reset", result, 32'h003F003F);
    rst_n = 1'b1;
    step();
    chk("R1 first clock after release", result, 32'h003F003F);
    repeat (4) step();
    chk("R5 R9 all active normal class", result, model());

    // single-source sweep over every source, both classes, varied slot
    for (int s = 0; s < NSRC; s++) begin
      for (int st = 0; st < 2; st++) begin
        int k = (s * 7 + st * 11) % NS;
        clear_all();
        slot_vld[k] = 1'b1; b_id[k] = 6'(s);
        set_src(s, 1'b1, st[0]);
        step();
        if (st == 1) chk("R4 R6 R9 fast single", result, {16'h003F, 1'b1, 9'd0, 6'(s)});
        else         chk("R4 R7 R9 normal single", result, {1'b1, 9'd0, 6'(s), 16'h003F});
        // R3: same slot, source not active
        set_src(s, 1'b0, st[0]);
        step();
        chk("R3 inactive source", result, 32'h003F003F);
      end
    end

    // R2: out-of-range numbers and disabled slots
    for (int v = 40; v < 64; v++) begin
      clear_all();
      act_lo = '1; act_hi = '1; steer_lo = rnd(); steer_hi = 8'(rnd());
      for (int i = 0; i < NS; i++) b_id[i] = 6'(v);
      slot_vld = '1;
      step();
      chk("R2 out of range id", result, 32'h003F003F);
    end
    clear_all();
    act_lo = '1; act_hi = '1; steer_lo = 32'h5555_5555; steer_hi = 8'h55;
    step();
    chk("R2 all slots disabled", result, 32'h003F003F);

    // R5 R11: full permutation table with random activity and steering
    for (int n = 0; n < 300; n++) begin
      for (int i = 0; i < NS; i++) b_id[i] = 6'((i * 13 + n) % NSRC);
      slot_vld = {rnd(), rnd()} | ((n % 3 == 0) ? {NS{1'b1}} : '0);
      act_lo = rnd() & rnd(); act_hi = 8'(rnd());
      steer_lo = rnd(); steer_hi = 8'(rnd());
      step();
      chk("R5 R11 random table", result, model());
    end

    // R11: both classes at once, fixed case
    clear_all();
    slot_vld = '1;
    set_src(9, 1'b1, 1'b1); set_src(35, 1'b1, 1'b0);
    step();
    chk("R11 both classes", result, {1'b1, 9'd0, 6'd35, 1'b1, 9'd0, 6'd9});

    // R12: duplicate entries, higher-rank slot reports, lower rank cannot displace
    clear_all();
    slot_vld[3] = 1'b1; b_id[3] = 6'd7;
    slot_vld[10] = 1'b1; b_id[10] = 6'd7;
    slot_vld[20] = 1'b1; b_id[20] = 6'd21;
    set_src(7, 1'b1, 1'b0); set_src(21, 1'b1, 1'b0);
    step();
    chk("R12 duplicate slots", result, {1'b1, 9'd0, 6'd7, 16'h003F});
    slot_vld[3] = 1'b0;
    step();
    chk("R12 duplicate lower slot", result, {1'b1, 9'd0, 6'd7, 16'h003F});
    b_id[10] = 6'd50;
    step();
    chk("R5 next rank after invalid", result, {1'b1, 9'd0, 6'd21, 16'h003F});

    // R10: one-cycle latency
    prev = result;
    clear_all();
    slot_vld[0] = 1'b1; b_id[0] = 6'd33;
    set_src(33, 1'b1, 1'b1);
    #1;
    chk("R10 old value before edge", result, prev);
    step();
    chk("R10 new value after edge", result, {16'h003F, 1'b1, 9'd0, 6'd33});

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule